// File: doc/BRIEF.md
# Time-Bounded Response Distance Verifier

This block makes the accept-or-reject decision on the verifying side of a delay-signature authentication exchange. A start strobe marks the moment the device under test is handed its configuration. The device then answers with a stream of single response bits. Each queried cell answers a fixed number of clock pulses per challenge. The block counts the ones in each such group. It compares that count with a predicted count taken from the verifier's storage and adds up the absolute differences over every cell of every challenge. The sum, measured against the total number of response bits, is the normalized L1 distance between the measured and predicted ones-fraction vectors.

A cycle timer runs from the start strobe until the last expected response bit is accepted. The answer is accepted only if the distance falls below a fixed percentage threshold and the elapsed time does not exceed a bound supplied with the start strobe. The verdict is given as a one-cycle pass or fail pulse with a reason code. A late answer is always reported as late, even when its distance would have passed.

The controller has three states. In `ST_IDLE` it waits, and it moves to `ST_RUN` on a start strobe. In `ST_RUN` it takes response bits and the timer counts. A start strobe in this state restarts the run, and acceptance of the final bit moves it to `ST_DECIDE`. `ST_DECIDE` lasts one cycle and drives the verdict pulse. From there the controller returns to `ST_IDLE`, or goes to `ST_RUN` if a start strobe arrives in that same cycle.

Top module: `resp_dist_verifier`

## Requirements
- R1: Accepted response bits (`bit_valid_i` high while running) form groups of `NP` consecutive bits, one group per cell, with `NCELL*NCHAL` groups in a run. The ones count of a group (0 to `NP`) is compared with `expect_i` as sampled in the cycle that carries the group's last bit; `expect_i` is ignored on all other bits.
- R2: The distance sum is the total, over all groups, of the absolute difference between the measured ones count and the expected count. It is symmetric in the sign of the difference.
- R3: If the run is not late, it passes (reason 1) when `sum*100 < THR_PCT*NP*NCELL*NCHAL`. Otherwise it fails with reason 2. With the bench sizes (NP=8, 4 cells, 2 challenges, THR_PCT=15), a sum of 9 passes and a sum of 10 fails.
- R4: The elapsed time is the number of clock edges from the edge that samples the start strobe to the edge that accepts the last bit. If that count exceeds `bound_i` as sampled with the start strobe, the run fails with reason 3, whatever the distance.
- R5: The elapsed-time counter saturates at its all-ones value and never wraps.
- R6: The verdict is one single-cycle pulse on `pass_o` or `fail_o`, never both, in the cycle after the edge that accepts the last bit. `reason_o` is 1 with a pass and 2 or 3 with a fail, and it is 0 whenever no pulse is present.
- R7: Response bits presented while no run is active, and cycles with `bit_valid_i` low, have no effect on counts, sums or the verdict.
- R8: A start strobe during a run discards all partial counts and sums, restarts the timer and begins a new run.
- R9: After reset the block is idle with `pass_o`, `fail_o` low and `reason_o` 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Configuration-start strobe; begins or restarts a run |
| bound_i | input | TW | Maximum allowed elapsed cycles, sampled with `start_i` |
| bit_valid_i | input | 1 | Response bit present this cycle |
| bit_i | input | 1 | Response bit value |
| expect_i | input | $clog2(NP+1) | Predicted ones count for the current cell |
| pass_o | output | 1 | One-cycle accept pulse |
| fail_o | output | 1 | One-cycle reject pulse |
| reason_o | output | 2 | 0 none, 1 pass, 2 distance too large, 3 time bound exceeded |

## Verification
The distance path is tried with exact matches, with sums just below and just above the threshold, and with large mismatches in both directions. Together these separate an off-by-one threshold comparison and a one-sided absolute difference from correct behaviour. Placing garbage on `expect_i` everywhere except the last bit of each group shows when the expected count is sampled. The timing path is tried with back-to-back bits and with spaced bits, at bounds exactly equal to the elapsed count and one below it. That reveals any error in where the timer starts or stops, and a spaced run long enough to overflow the timer separates saturation from wrap-around. Stray bits sent while idle, a run aborted by a fresh start, and a late run with a bad distance check the ignore rule, the restart rule and the late-over-distance priority.

// File: rtl/rdv_pkg.sv
package rdv_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_RUN    = 2'd1,
        ST_DECIDE = 2'd2
    } rdv_state_e;

    typedef enum logic [1:0] {
        RSN_NONE = 2'd0,
        RSN_PASS = 2'd1,
        RSN_DIST = 2'd2,
        RSN_LATE = 2'd3
    } rdv_reason_e;
endpackage

// File: rtl/rdv_group_count.sv
// Counts ones within each group of NP accepted bits.
module rdv_group_count #(
    parameter int NP = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       clr_i,
    input  logic                       vld_i,
    input  logic                       bit_i,
    output logic                       grp_done_o,
    output logic [$clog2(NP+1)-1:0]    grp_ones_o
);
    localparam int IW = (NP > 1) ? $clog2(NP) : 1;
    localparam int CW = $clog2(NP + 1);

    logic [IW-1:0] idx_q;
    logic [CW-1:0] ones_q;

    assign grp_done_o = vld_i && (idx_q == IW'(NP - 1));
    assign grp_ones_o = ones_q + CW'(bit_i);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q  <= '0;
            ones_q <= '0;
        end else if (clr_i) begin
            idx_q  <= '0;
            ones_q <= '0;
        end else if (vld_i) begin
            if (grp_done_o) begin
                idx_q  <= '0;
                ones_q <= '0;
            end else begin
                idx_q  <= idx_q + IW'(1);
                ones_q <= grp_ones_o;
            end
        end
    end
endmodule

// File: rtl/rdv_dist_acc.sv
// Accumulates |measured - expected| over all groups of a run.
module rdv_dist_acc #(
    parameter int NP   = 8,
    parameter int NGRP = 256
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              clr_i,
    input  logic                              grp_done_i,
    input  logic [$clog2(NP+1)-1:0]           grp_ones_i,
    input  logic [$clog2(NP+1)-1:0]           expect_i,
    output logic                              last_o,
    output logic [$clog2(NP*NGRP+1)-1:0]      sum_next_o
);
    localparam int CW = $clog2(NP + 1);
    localparam int SW = $clog2(NP * NGRP + 1);
    localparam int GW = (NGRP > 1) ? $clog2(NGRP) : 1;

    logic [SW-1:0] sum_q;
    logic [GW-1:0] gcnt_q;
    logic [CW-1:0] diff;

    assign diff       = (grp_ones_i >= expect_i) ? (grp_ones_i - expect_i)
                                                 : (expect_i - grp_ones_i);
    assign sum_next_o = sum_q + SW'(diff);
    assign last_o     = grp_done_i && (gcnt_q == GW'(NGRP - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sum_q  <= '0;
            gcnt_q <= '0;
        end else if (clr_i) begin
            sum_q  <= '0;
            gcnt_q <= '0;
        end else if (grp_done_i) begin
            sum_q  <= sum_next_o;
            gcnt_q <= last_o ? '0 : gcnt_q + GW'(1);
        end
    end
endmodule

// File: rtl/rdv_timer.sv
// Elapsed-cycle counter; loaded with 1 at the start edge, saturating.
module rdv_timer #(
    parameter int TW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic          run_i,
    output logic [TW-1:0] val_o
);
    logic [TW-1:0] val_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            val_q <= '0;
        end else if (load_i) begin
            val_q <= TW'(1);
        end else if (run_i && (val_q != '1)) begin
            val_q <= val_q + TW'(1);
        end
    end

    assign val_o = val_q;
endmodule

// File: rtl/resp_dist_verifier.sv
module resp_dist_verifier
    import rdv_pkg::*;
#(
    parameter int NP      = 8,
    parameter int NCELL   = 64,
    parameter int NCHAL   = 4,
    parameter int TW      = 16,
    parameter int THR_PCT = 15
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start_i,
    input  logic [TW-1:0]           bound_i,
    input  logic                    bit_valid_i,
    input  logic                    bit_i,
    input  logic [$clog2(NP+1)-1:0] expect_i,
    output logic                    pass_o,
    output logic                    fail_o,
    output logic [1:0]              reason_o
);
    localparam int NGRP  = NCELL * NCHAL;
    localparam int CW    = $clog2(NP + 1);
    localparam int SW    = $clog2(NP * NGRP + 1);
    localparam int PW    = SW + 8;
    localparam int LIMIT = THR_PCT * NP * NGRP;

    rdv_state_e    state_q, state_d;
    logic          running;
    logic          grp_done;
    logic [CW-1:0] grp_ones;
    logic          last_grp;
    logic [SW-1:0] sum_next;
    logic [TW-1:0] elapsed;
    logic [TW-1:0] bound_q;
    logic          late_q, close_q;
    logic          close_now;

    assign running = (state_q == ST_RUN) && !start_i;

    rdv_group_count #(.NP(NP)) u_grp (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr_i      (start_i),
        .vld_i      (bit_valid_i && running),
        .bit_i      (bit_i),
        .grp_done_o (grp_done),
        .grp_ones_o (grp_ones)
    );

    rdv_dist_acc #(.NP(NP), .NGRP(NGRP)) u_acc (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr_i      (start_i),
        .grp_done_i (grp_done),
        .grp_ones_i (grp_ones),
        .expect_i   (expect_i),
        .last_o     (last_grp),
        .sum_next_o (sum_next)
    );

    rdv_timer #(.TW(TW)) u_tmr (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (start_i),
        .run_i  (state_q == ST_RUN),
        .val_o  (elapsed)
    );

    assign close_now = (PW'(sum_next) * PW'(100)) < PW'(LIMIT);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start_i) state_d = ST_RUN;
            ST_RUN:    if (start_i) state_d = ST_RUN;
                       else if (last_grp) state_d = ST_DECIDE;
            ST_DECIDE: state_d = start_i ? ST_RUN : ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // Bound capture and verdict latch
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bound_q <= '0;
            late_q  <= 1'b0;
            close_q <= 1'b0;
        end else begin
            if (start_i) begin
                bound_q <= bound_i;
            end
            if (running && last_grp) begin
                late_q  <= elapsed > bound_q;
                close_q <= close_now;
            end
        end
    end

    // Outputs
    always_comb begin
        pass_o   = 1'b0;
        fail_o   = 1'b0;
        reason_o = RSN_NONE;
        if (state_q == ST_DECIDE) begin
            if (late_q) begin
                fail_o   = 1'b1;
                reason_o = RSN_LATE;
            end else if (close_q) begin
                pass_o   = 1'b1;
                reason_o = RSN_PASS;
            end else begin
                fail_o   = 1'b1;
                reason_o = RSN_DIST;
            end
        end
    end
endmodule

// File: rtl/resp_dist_verifier_checker.sv
module resp_dist_verifier_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       start_i,
    input logic       pass_o,
    input logic       fail_o,
    input logic [1:0] reason_o
);
    a_r6_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(pass_o && fail_o));

    a_r6_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (pass_o || fail_o) |=> !(pass_o || fail_o));

    a_r6_pass_reason: assert property (@(posedge clk) disable iff (!rst_n)
        pass_o |-> (reason_o == 2'd1));

    a_r3_fail_reason: assert property (@(posedge clk) disable iff (!rst_n)
        fail_o |-> (reason_o == 2'd2 || reason_o == 2'd3));

    a_r9_quiet_reason: assert property (@(posedge clk) disable iff (!rst_n)
        !(pass_o || fail_o) |-> (reason_o == 2'd0));

    a_r8_start_silences: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> !(pass_o || fail_o));
endmodule

bind resp_dist_verifier resp_dist_verifier_checker u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (start_i),
    .pass_o   (pass_o),
    .fail_o   (fail_o),
    .reason_o (reason_o)
);

// File: tb/resp_dist_verifier_bench.sv
module resp_dist_verifier_bench;
    localparam int NP = 8, NCELL = 4, NCHAL = 2, TW = 8;
    localparam int NGRP = NCELL * NCHAL;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start_i = 1'b0;
    logic [TW-1:0] bound_i = '0;
    logic         bit_valid_i = 1'b0;
    logic         bit_i = 1'b0;
    logic [3:0]   expect_i = '0;
    logic         pass_o, fail_o;
    logic [1:0]   reason_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    resp_dist_verifier #(.NP(NP), .NCELL(NCELL), .NCHAL(NCHAL), .TW(TW), .THR_PCT(15))
        u_resp_dist_verifier (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .bound_i(bound_i),
        .bit_valid_i(bit_valid_i), .bit_i(bit_i), .expect_i(expect_i),
        .pass_o(pass_o), .fail_o(fail_o), .reason_o(reason_o)
    );

    // oa: ones per group, ea: expected for groups 1..7, e0: expected for group 0
    typedef struct packed {
        logic [3:0] oa;
        logic [3:0] ea;
        logic [3:0] e0;
        logic [3:0] gap;
        logic [7:0] bound;
        logic [1:0] rsn;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t TBL [NV] = '{
        '{4'd4, 4'd4, 4'd4, 4'd0, 8'd255, 2'd1},  // sum 0
        '{4'd8, 4'd8, 4'd0, 4'd0, 8'd255, 2'd1},  // sum 8
        '{4'd3, 4'd4, 4'd5, 4'd0, 8'd255, 2'd1},  // sum 9, just below
        '{4'd3, 4'd4, 4'd6, 4'd0, 8'd255, 2'd2},  // sum 10, at limit
        '{4'd0, 4'd8, 4'd8, 4'd0, 8'd255, 2'd2},  // sum 64, under
        '{4'd8, 4'd0, 4'd0, 4'd0, 8'd255, 2'd2},  // sum 64, over
        '{4'd5, 4'd5, 4'd5, 4'd0, 8'd64,  2'd1},  // elapsed 64 == bound
        '{4'd5, 4'd5, 4'd5, 4'd0, 8'd63,  2'd3},  // elapsed 64 > bound
        '{4'd0, 4'd8, 4'd8, 4'd0, 8'd63,  2'd3},  // late beats distance
        '{4'd2, 4'd2, 4'd2, 4'd1, 8'd127, 2'd1},  // elapsed 127 == bound
        '{4'd2, 4'd2, 4'd2, 4'd1, 8'd126, 2'd3},  // elapsed 127 > bound
        '{4'd6, 4'd6, 4'd6, 4'd4, 8'd100, 2'd3}   // elapsed 316 saturates
    };

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic do_start(input logic [7:0] bnd);
        @(negedge clk);
        start_i = 1'b1;
        bound_i = bnd;
        bit_valid_i = 1'b0;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    // Streams NGRP groups after a start; expect_i carries garbage except on
    // each group's last bit (R1). Returns sampled outputs in the verdict cycle.
    task automatic stream(input int oa, input int ea, input int e0, input int gap,
                          output logic p, output logic f, output logic [1:0] r);
        for (int g = 0; g < NGRP; g++) begin
            for (int k = 0; k < NP; k++) begin
                if (g == NGRP - 1 && k == NP - 1)
                    check(!pass_o && !fail_o, "R6 early pulse", {pass_o, fail_o}, 0);
                bit_valid_i = 1'b1;
                bit_i       = (k < oa);
                expect_i    = (k == NP - 1) ? ((g == 0) ? 4'(e0) : 4'(ea)) : 4'hF;
                @(negedge clk);
                if (!(g == NGRP - 1 && k == NP - 1)) begin
                    for (int w = 0; w < gap; w++) begin
                        bit_valid_i = 1'b0;
                        bit_i       = 1'b1;
                        @(negedge clk);
                    end
                end
            end
        end
        bit_valid_i = 1'b0;
        p = pass_o;
        f = fail_o;
        r = reason_o;
    endtask

    task automatic run_case(input vec_t v, input string tag);
        logic p, f;
        logic [1:0] r;
        do_start(v.bound);
        stream(int'(v.oa), int'(v.ea), int'(v.e0), int'(v.gap), p, f, r);
        check(r == v.rsn, tag, int'(r), int'(v.rsn));
        check(p == (v.rsn == 2'd1) && f == (v.rsn != 2'd1), "R6 pulse kind",
              {p, f}, (v.rsn == 2'd1) ? 2 : 1);
        @(negedge clk);
        check(!pass_o && !fail_o && reason_o == 2'd0, "R6 single cycle",
              {pass_o, fail_o, reason_o}, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(!pass_o && !fail_o, "R9 reset pulses", {pass_o, fail_o}, 0);
        check(reason_o == 2'd0, "R9 reset reason", int'(reason_o), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // Table of vectors: R1 R2 R3 R4 R5
        for (int i = 0; i < NV; i++) begin
            string tag;
            if (TBL[i].gap == 4'd4)       tag = "R5 saturation";
            else if (TBL[i].rsn == 2'd3)  tag = "R4 time bound";
            else if (TBL[i].oa == 4'd8 && TBL[i].ea == 4'd0) tag = "R2 symmetric";
            else                          tag = "R3 R1 distance";
            run_case(TBL[i], tag);
        end

        // R7: stray bits while idle must not disturb the next run
        for (int k = 0; k < 5; k++) begin
            bit_valid_i = 1'b1;
            bit_i       = 1'b1;
            expect_i    = 4'd0;
            @(negedge clk);
            check(!pass_o && !fail_o, "R7 idle bits", {pass_o, fail_o}, 0);
        end
        bit_valid_i = 1'b0;
        run_case('{4'd4, 4'd4, 4'd4, 4'd0, 8'd255, 2'd1}, "R7 after idle bits");

        // R8: abort a bad partial run with a fresh start
        do_start(8'd255);
        for (int k = 0; k < 30; k++) begin
            bit_valid_i = 1'b1;
            bit_i       = 1'b0;
            expect_i    = 4'd8;
            @(negedge clk);
        end
        bit_valid_i = 1'b0;
        run_case('{4'd7, 4'd7, 4'd7, 4'd0, 8'd255, 2'd1}, "R8 restart");

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule